// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the per-channel register front end of a descriptor-driven DMA controller. A processor reaches it with 32-bit word accesses. The upper address bits select a channel, and each channel has an 8 KiB window. Within that window the block keeps the descriptor pointers, the configuration and command words, the interrupt mask and raw interrupt bits, and the last stream command. It also assembles a status word for each channel.

Some writes start work on the data engine. A stream command can ask for the current data descriptor to be loaded, for the channel to start, or for a context descriptor to be loaded. A write to the command register asks a channel that is parked at end-of-list to resume. The block turns these requests into one or two descriptor fetches over a request/acknowledge handshake, and updates its pointers from the fetched fields. The data engine sends interrupt causes and end-of-list events back through a small event port. The block then drives one interrupt line per channel.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel index is `busAddr[15:13]` and the register offset is `busAddr[12:0]`. An access to a channel index at or above the channel count writes nothing and reads 0.
- R2: The saved-data pointer (0x58), saved-buffer pointer (0x5C), group pointer (0x60), group-down pointer (0x7C), command (0x80), config (0x84) and stream command (0x9C) read back the last value written. Unmapped offsets read 0 and ignore writes.
- R3: Only `busSize == 2'b10` (a 32-bit word) is performed. Any other size changes nothing, reads 0, and raises `busErr` in the cycle after acceptance.
- R4: The status word (0x88) carries the channel state in bits [2:0] (0 after reset, 4 when running), the end-of-list flag in bit 5, and a stream-source field of zero in bits [15:8]. All other bits are 0.
- R5: An event with `evtIntr` sets those bits in the raw interrupt register (0x94). A write to the acknowledge offset (0x90) clears the written 1-bits of the raw register. The acknowledge offset always reads 0.
- R6: The mask register (0x8C) keeps the low INTR_W bits written to it. The masked register (0x98) reads raw AND mask. `irq[ch]` is high exactly when that value is nonzero.
- R7: A stream-command write uses only bits [9:0]. If any bit of 0x140 is set, a data-descriptor fetch (`fetchKind` 0) is made at the saved-data pointer. The saved-buffer pointer then takes the fetched buffer field, and the descriptor's end-of-list bit is kept.
- R8: Stream-command bit 0x20, given together with a data load, starts the channel after the fetch. Starting clears the end-of-list flag and sets the state to running, but only if `clientPresent[ch]` is 1; otherwise nothing changes.
- R9: Stream-command bit 0x200 makes a context fetch (`fetchKind` 1) at the group-down pointer. Its next field goes to the saved-data pointer and its buffer field goes to the saved-buffer pointer. When bit 0x200 and a data load are both requested, the data fetch comes first.
- R10: A command-register write is ignored unless config bit 0 is 1, a client is attached, config bit 1 is 0, the state is running, and the last fetched data descriptor had its end-of-list bit set.
- R11: An accepted command write re-fetches the data descriptor at the saved-data pointer. If that descriptor's end-of-list bit is now clear and the channel's end-of-list flag is set, the saved-data pointer takes the next field, that descriptor is fetched, and the channel is started.
- R12: `fetchReq` stays high with a stable `fetchAddr` until `fetchAck`. `busReady` is low while a fetch sequence is in progress.
- R13: An event with `evtEol` sets the channel's end-of-list flag. `runOut[ch]` is high when the state is running and the end-of-list flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size code, 2'b10 = 32-bit word |
| busAddr | input | BUS_AW | Byte address relative to the block base |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access accepted when high together with busValid |
| busRdata | output | 32 | Read data, valid the cycle after acceptance |
| busErr | output | 1 | Non-word access flag, cycle after acceptance |
| clientPresent | input | NUM_CH | Client attached per channel |
| evtValid | input | 1 | Engine event strobe |
| evtCh | input | CH_W | Event channel |
| evtIntr | input | INTR_W | Interrupt causes to set |
| evtEol | input | 1 | Channel reached end-of-list |
| fetchReq | output | 1 | Descriptor fetch request |
| fetchKind | output | 1 | 0 = data descriptor, 1 = context descriptor |
| fetchAddr | output | 32 | Descriptor address |
| fetchAck | input | 1 | Fetch complete, fields valid |
| fetchEol | input | 1 | Fetched end-of-list bit |
| fetchNext | input | 32 | Fetched next / saved-data field |
| fetchBuf | input | 32 | Fetched buffer / saved-buffer field |
| irq | output | NUM_CH | Interrupt line per channel |
| runOut | output | NUM_CH | Channel running and not at end-of-list |

## Verification
The hardest case to reach is a successful resume. The channel has to be enabled, have a client and be running, its last fetched descriptor must carry end-of-list, and the engine must have reported end-of-list. Only then can a command write lead to a re-fetch whose end-of-list bit has been cleared. The bench gets there step by step: a stream load while its fetch responder returns end-of-list set, then a start, then an end-of-list event. It then flips the responder's end-of-list bit before the command write, so that it can see the two-fetch path, and it first tries each blocking condition in turn.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;
  localparam logic [12:0] OFF_SDATA = 13'h058;
  localparam logic [12:0] OFF_SBUF  = 13'h05C;
  localparam logic [12:0] OFF_GRP   = 13'h060;
  localparam logic [12:0] OFF_GDOWN = 13'h07C;
  localparam logic [12:0] OFF_CMD   = 13'h080;
  localparam logic [12:0] OFF_CFG   = 13'h084;
  localparam logic [12:0] OFF_STAT  = 13'h088;
  localparam logic [12:0] OFF_MASK  = 13'h08C;
  localparam logic [12:0] OFF_ACK   = 13'h090;
  localparam logic [12:0] OFF_RAW   = 13'h094;
  localparam logic [12:0] OFF_MINT  = 13'h098;
  localparam logic [12:0] OFF_STRM  = 13'h09C;

  localparam logic [9:0] SC_LOAD_DATA = 10'h140;
  localparam logic [9:0] SC_START     = 10'h020;
  localparam logic [9:0] SC_LOAD_CTX  = 10'h200;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_STOPPED = 3'd2,
    ST_RUNNING = 3'd4
  } chState_e;

  // strobes from control to the register datapath
  typedef struct packed {
    logic        regWr;
    logic [12:0] off;
    logic [31:0] wdata;
    logic        ldData;
    logic        ldCtx;
    logic        setNext;
    logic        start;
  } strobe_t;

  // view of the selected channel returned to control
  typedef struct packed {
    logic        enabled;
    logic        stopped;
    logic        running;
    logic        curEol;
    logic        atEol;
    logic [31:0] savedData;
    logic [31:0] groupDown;
    logic [31:0] readWord;
  } view_t;
endpackage

// File: rtl/dma_chreg_data.sv
module dma_chreg_data
  import dma_chreg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int INTR_W = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CH_W-1:0]   selCh,
  input  logic [NUM_CH-1:0] clientPresent,
  input  logic              evtValid,
  input  logic [CH_W-1:0]   evtCh,
  input  logic [INTR_W-1:0] evtIntr,
  input  logic              evtEol,
  input  logic              fetchEol,
  input  logic [31:0]       fetchNext,
  input  logic [31:0]       fetchBuf,
  output view_t             view,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] runOut
);
  localparam int PAD_W = 32 - INTR_W;

  logic [31:0]       savedData [NUM_CH];
  logic [31:0]       savedBuf  [NUM_CH];
  logic [31:0]       groupPtr  [NUM_CH];
  logic [31:0]       groupDown [NUM_CH];
  logic [31:0]       cmdReg    [NUM_CH];
  logic [31:0]       cfgReg    [NUM_CH];
  logic [31:0]       streamReg [NUM_CH];
  logic [INTR_W-1:0] maskReg   [NUM_CH];
  logic [INTR_W-1:0] rawReg    [NUM_CH];
  logic [INTR_W-1:0] ackBits   [NUM_CH];
  chState_e          chState   [NUM_CH];
  logic [NUM_CH-1:0] eolFlag, curEol, wrHit, seqHit, evtHit;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      seqHit[i]  = (selCh == CH_W'(i));
      wrHit[i]   = strb.regWr && seqHit[i];
      evtHit[i]  = evtValid && (evtCh == CH_W'(i));
      ackBits[i] = (wrHit[i] && strb.off == OFF_ACK) ? strb.wdata[INTR_W-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        savedData[i] <= '0; savedBuf[i]  <= '0; groupPtr[i]  <= '0;
        groupDown[i] <= '0; cmdReg[i]    <= '0; cfgReg[i]    <= '0;
        streamReg[i] <= '0; maskReg[i]   <= '0; rawReg[i]    <= '0;
        chState[i]   <= ST_RESET;
      end
      eolFlag <= '0;
      curEol  <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrHit[i]) begin
          case (strb.off)
            OFF_SDATA: savedData[i] <= strb.wdata;
            OFF_SBUF:  savedBuf[i]  <= strb.wdata;
            OFF_GRP:   groupPtr[i]  <= strb.wdata;
            OFF_GDOWN: groupDown[i] <= strb.wdata;
            OFF_CMD:   cmdReg[i]    <= strb.wdata;
            OFF_CFG:   cfgReg[i]    <= strb.wdata;
            OFF_STRM:  streamReg[i] <= strb.wdata;
            OFF_MASK:  maskReg[i]   <= strb.wdata[INTR_W-1:0];
            default: ;
          endcase
        end
        rawReg[i] <= (rawReg[i] & ~ackBits[i]) | (evtHit[i] ? evtIntr : '0);
        if (seqHit[i] && strb.ldData) begin
          curEol[i]   <= fetchEol;
          savedBuf[i] <= fetchBuf;
        end
        if (seqHit[i] && (strb.setNext || strb.ldCtx)) savedData[i] <= fetchNext;
        if (seqHit[i] && strb.ldCtx) savedBuf[i] <= fetchBuf;
        if (seqHit[i] && strb.start && clientPresent[i]) begin
          eolFlag[i] <= 1'b0;
          chState[i] <= ST_RUNNING;
        end
        if (evtHit[i] && evtEol) eolFlag[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    view.enabled   = cfgReg[selCh][0] && clientPresent[selCh];
    view.stopped   = cfgReg[selCh][1];
    view.running   = (chState[selCh] == ST_RUNNING);
    view.curEol    = curEol[selCh];
    view.atEol     = eolFlag[selCh];
    view.savedData = savedData[selCh];
    view.groupDown = groupDown[selCh];
    case (strb.off)
      OFF_SDATA: view.readWord = savedData[selCh];
      OFF_SBUF:  view.readWord = savedBuf[selCh];
      OFF_GRP:   view.readWord = groupPtr[selCh];
      OFF_GDOWN: view.readWord = groupDown[selCh];
      OFF_CMD:   view.readWord = cmdReg[selCh];
      OFF_CFG:   view.readWord = cfgReg[selCh];
      OFF_STRM:  view.readWord = streamReg[selCh];
      OFF_STAT:  view.readWord = {16'h0, 8'h00, 2'b00, eolFlag[selCh], 2'b00, chState[selCh]};
      OFF_MASK:  view.readWord = {{PAD_W{1'b0}}, maskReg[selCh]};
      OFF_RAW:   view.readWord = {{PAD_W{1'b0}}, rawReg[selCh]};
      OFF_MINT:  view.readWord = {{PAD_W{1'b0}}, rawReg[selCh] & maskReg[selCh]};
      default:   view.readWord = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    assign irq[g]    = |(rawReg[g] & maskReg[g]);
    assign runOut[g] = (chState[g] == ST_RUNNING) && !eolFlag[g];

    // R8
    start_client_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chState[g] == ST_RUNNING) |-> $past(clientPresent[g]));
    // R8
    start_eol_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chState[g] == ST_RUNNING) |-> !eolFlag[g] || $past(evtHit[g] && evtEol));
    // R6
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
      irq[g] |-> (maskReg[g] != '0));
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ackBits[g] != '0 && !evtHit[g]) |=> ((rawReg[g] & $past(ackBits[g])) == '0));
  end
endmodule

// File: rtl/dma_chreg_ctrl.sv
module dma_chreg_ctrl
  import dma_chreg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int BUS_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              fetchReq,
  output logic              fetchKind,
  output logic [31:0]       fetchAddr,
  input  logic              fetchAck,
  input  logic              fetchEol,
  input  view_t             view,
  output strobe_t           strb,
  output logic [CH_W-1:0]   selCh
);
  localparam int IDX_W = BUS_AW - 13;

  typedef enum logic [2:0] {SQ_IDLE, SQ_DLOAD, SQ_CONT1, SQ_CONT2, SQ_CLOAD} seq_e;

  seq_e             seq;
  logic [CH_W-1:0]  seqCh;
  logic             pendStart, pendCtx;
  logic [IDX_W-1:0] busIdx;
  logic             chOk, wordOk, accept, wrAcc, contGate;

  assign busIdx   = busAddr[BUS_AW-1:13];
  assign chOk     = (32'(busIdx) < NUM_CH);
  assign wordOk   = (busSize == 2'b10);
  assign busReady = (seq == SQ_IDLE);
  assign accept   = busValid && busReady;
  assign wrAcc    = accept && busWrite && wordOk && chOk;
  assign selCh    = (seq == SQ_IDLE) ? busIdx[CH_W-1:0] : seqCh;
  assign contGate = view.enabled && !view.stopped && view.running && view.curEol;

  assign fetchReq  = (seq != SQ_IDLE);
  assign fetchKind = (seq == SQ_CLOAD);
  assign fetchAddr = (seq == SQ_CLOAD) ? view.groupDown : view.savedData;

  always_comb begin
    strb       = '0;
    strb.off   = busAddr[12:0];
    strb.wdata = busWdata;
    strb.regWr = wrAcc;
    if (fetchAck) begin
      case (seq)
        SQ_DLOAD: begin strb.ldData = 1'b1; strb.start = pendStart; end
        SQ_CONT1: begin strb.ldData = 1'b1; strb.setNext = !fetchEol && view.atEol; end
        SQ_CONT2: begin strb.ldData = 1'b1; strb.start = 1'b1; end
        SQ_CLOAD: strb.ldCtx = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq       <= SQ_IDLE;
      seqCh     <= '0;
      pendStart <= 1'b0;
      pendCtx   <= 1'b0;
    end else begin
      case (seq)
        SQ_IDLE: if (wrAcc) begin
          seqCh <= busIdx[CH_W-1:0];
          if (strb.off == OFF_CMD && contGate) seq <= SQ_CONT1;
          else if (strb.off == OFF_STRM) begin
            pendStart <= |(busWdata[9:0] & SC_START);
            pendCtx   <= |(busWdata[9:0] & SC_LOAD_CTX);
            if (|(busWdata[9:0] & SC_LOAD_DATA))     seq <= SQ_DLOAD;
            else if (|(busWdata[9:0] & SC_LOAD_CTX)) seq <= SQ_CLOAD;
          end
        end
        SQ_DLOAD: if (fetchAck) seq <= pendCtx ? SQ_CLOAD : SQ_IDLE;
        SQ_CONT1: if (fetchAck) seq <= (!fetchEol && view.atEol) ? SQ_CONT2 : SQ_IDLE;
        SQ_CONT2: if (fetchAck) seq <= SQ_IDLE;
        SQ_CLOAD: if (fetchAck) seq <= SQ_IDLE;
        default:  seq <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busErr <= accept && !wordOk;
      if (accept && !busWrite) busRdata <= (wordOk && chOk) ? view.readWord : '0;
    end
  end

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> (fetchReq && $stable(fetchAddr) && $stable(fetchKind)));
  // R3
  size_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && busSize != 2'b10) |=> busErr);
  // R12
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && strb.off == OFF_STRM && |(busWdata[9:0] & (SC_LOAD_DATA | SC_LOAD_CTX))) |=> !busReady);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chreg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int INTR_W = 4,
  parameter int BUS_AW = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  output logic              busErr,
  input  logic [NUM_CH-1:0] clientPresent,
  input  logic              evtValid,
  input  logic [CH_W-1:0]   evtCh,
  input  logic [INTR_W-1:0] evtIntr,
  input  logic              evtEol,
  output logic              fetchReq,
  output logic              fetchKind,
  output logic [31:0]       fetchAddr,
  input  logic              fetchAck,
  input  logic              fetchEol,
  input  logic [31:0]       fetchNext,
  input  logic [31:0]       fetchBuf,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] runOut
);
  strobe_t         strb;
  view_t           view;
  logic [CH_W-1:0] selCh;

  dma_chreg_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .BUS_AW(BUS_AW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .busErr(busErr),
    .fetchReq(fetchReq), .fetchKind(fetchKind), .fetchAddr(fetchAddr),
    .fetchAck(fetchAck), .fetchEol(fetchEol),
    .view(view), .strb(strb), .selCh(selCh)
  );

  dma_chreg_data #(.NUM_CH(NUM_CH), .INTR_W(INTR_W), .CH_W(CH_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .selCh(selCh),
    .clientPresent(clientPresent),
    .evtValid(evtValid), .evtCh(evtCh), .evtIntr(evtIntr), .evtEol(evtEol),
    .fetchEol(fetchEol), .fetchNext(fetchNext), .fetchBuf(fetchBuf),
    .view(view), .irq(irq), .runOut(runOut)
  );
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  import dma_chreg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int INTR_W = 4;
  localparam int BUS_AW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 0, busWrite = 0;
  logic [1:0] busSize = 2'b10;
  logic [BUS_AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busReady, busErr;
  logic [NUM_CH-1:0] clientPresent = 4'b0101;
  logic evtValid = 0, evtEol = 0;
  logic [1:0] evtCh = '0;
  logic [INTR_W-1:0] evtIntr = '0;
  logic fetchReq, fetchKind, fetchAck = 0, fetchEol = 0;
  logic [31:0] fetchAddr, fetchNext = '0, fetchBuf = '0;
  logic [NUM_CH-1:0] irq, runOut;

  dma_chan_regs #(.NUM_CH(NUM_CH), .INTR_W(INTR_W), .BUS_AW(BUS_AW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nErrors = 0, fetchCount = 0, waitCnt = 0;
  logic respEol = 1'b0;
  logic [31:0] lastAddr = '0, firstAddr = '0;
  logic lastKind = 1'b0;
  logic [7:0] kindLog = '0;
  logic [31:0] expSd [NUM_CH], expGd [NUM_CH];
  logic [3:0] expRaw [NUM_CH], expMask [NUM_CH];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] regAddr(input int ch, input logic [12:0] off);
    return {3'(ch), off};
  endfunction

  task automatic busAccess(input logic wr, input logic [15:0] addr, input logic [31:0] wd,
                           input logic [1:0] sz, output logic [31:0] rd, output logic err);
    @(negedge clk);
    while (!busReady) @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = addr; busWdata = wd; busSize = sz;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    rd = busRdata; err = busErr;
  endtask

  task automatic wr(input int ch, input logic [12:0] off, input logic [31:0] v);
    logic [31:0] d; logic e;
    busAccess(1'b1, regAddr(ch, off), v, 2'b10, d, e);
  endtask

  task automatic rd(input int ch, input logic [12:0] off, output logic [31:0] v);
    logic e;
    busAccess(1'b0, regAddr(ch, off), 32'h0, 2'b10, v, e);
  endtask

  task automatic event_pulse(input int ch, input logic [3:0] bits, input logic eol);
    @(negedge clk);
    evtValid = 1; evtCh = 2'(ch); evtIntr = bits; evtEol = eol;
    @(negedge clk);
    evtValid = 0; evtIntr = '0; evtEol = 0;
  endtask

  function automatic logic [31:0] statusWord(input logic run, input logic eol);
    return {26'h0, eol, 2'b00, run, 2'b00};
  endfunction

  // fetch responder: two-cycle latency, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (fetchAck) fetchAck = 0;
      else if (fetchReq) begin
        if (waitCnt == 0) begin firstAddr = fetchAddr; waitCnt = 1; end
        else if (waitCnt < 2) waitCnt++;
        else begin
          check("R12 fetchAddr held until ack", fetchAddr, firstAddr);
          fetchAck = 1; fetchEol = respEol;
          fetchNext = fetchAddr + 32'h40; fetchBuf = fetchAddr + 32'h1000;
          lastAddr = fetchAddr; lastKind = fetchKind;
          kindLog = {kindLog[6:0], fetchKind};
          fetchCount++; waitCnt = 0;
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d;
    logic e;
    int fc;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rstN = 1;

    // reset state
    rd(0, OFF_STAT, v); check("R4 status after reset", v, 32'h0);
    rd(0, OFF_RAW, v);  check("R5 raw after reset", v, 32'h0);
    check("R6 irq after reset", 32'(irq), 32'h0);

    // pointer registers
    for (int ch = 0; ch < NUM_CH; ch++) begin
      expSd[ch] = $urandom; expGd[ch] = $urandom;
      wr(ch, OFF_SDATA, expSd[ch]); wr(ch, OFF_GDOWN, expGd[ch]);
      v = $urandom; wr(ch, OFF_GRP, v); rd(ch, OFF_GRP, d); check("R2 group pointer", d, v);
      v = $urandom; wr(ch, OFF_SBUF, v); rd(ch, OFF_SBUF, d); check("R2 saved buffer", d, v);
      rd(ch, OFF_SDATA, d); check("R2 saved data", d, expSd[ch]);
      rd(ch, OFF_GDOWN, d); check("R2 group down", d, expGd[ch]);
    end
    v = $urandom; wr(3, OFF_CFG, v); rd(3, OFF_CFG, d); check("R2 config readback", d, v);
    wr(3, OFF_STRM, 32'h010); rd(3, OFF_STRM, d); check("R2 stream readback", d, 32'h010);
    wr(3, OFF_CMD, 32'h1234); rd(3, OFF_CMD, d); check("R2 command readback", d, 32'h1234);
    wr(0, 13'h040, 32'hFFFF_FFFF); rd(0, 13'h040, d); check("R2 unmapped offset", d, 32'h0);
    rd(0, 13'h1058, d); check("R2 unmapped high offset", d, 32'h0);

    // R1 out-of-range channel
    wr(5, OFF_SDATA, 32'hBAD0_0001);
    rd(5, OFF_SDATA, d); check("R1 absent channel reads 0", d, 32'h0);
    rd(1, OFF_SDATA, d); check("R1 other channel untouched", d, expSd[1]);

    // R3 access size
    busAccess(1'b1, regAddr(0, OFF_SDATA), 32'hDEAD_BEEF, 2'b01, d, e);
    check("R3 busErr on short write", 32'(e), 32'h1);
    rd(0, OFF_SDATA, d); check("R3 short write ignored", d, expSd[0]);
    busAccess(1'b0, regAddr(0, OFF_SDATA), 32'h0, 2'b00, d, e);
    check("R3 busErr on short read", 32'(e), 32'h1);
    check("R3 short read returns 0", d, 32'h0);
    busAccess(1'b0, regAddr(0, OFF_SDATA), 32'h0, 2'b10, d, e);
    check("R3 no busErr on word", 32'(e), 32'h0);

    // R5 / R6 random interrupt traffic
    for (int ch = 0; ch < NUM_CH; ch++) begin expRaw[ch] = '0; expMask[ch] = '0; end
    for (int n = 0; n < 40; n++) begin
      int ch, op;
      ch = int'($urandom % NUM_CH); op = int'($urandom % 3);
      v = $urandom;
      if (op == 0) begin event_pulse(ch, v[3:0], 1'b0); expRaw[ch] |= v[3:0]; end
      else if (op == 1) begin wr(ch, OFF_MASK, v); expMask[ch] = v[3:0]; end
      else begin wr(ch, OFF_ACK, v); expRaw[ch] &= ~v[3:0]; end
      rd(ch, OFF_RAW, d);  check("R5 raw interrupt", d, 32'(expRaw[ch]));
      rd(ch, OFF_MINT, d); check("R6 masked interrupt", d, 32'(expRaw[ch] & expMask[ch]));
      check("R6 irq line", 32'(irq[ch]), 32'(|(expRaw[ch] & expMask[ch])));
    end
    rd(2, OFF_MASK, d); check("R6 mask keeps low bits", d, 32'(expMask[2]));
    rd(0, OFF_ACK, d); check("R5 ack reads 0", d, 32'h0);
    for (int ch = 0; ch < NUM_CH; ch++) wr(ch, OFF_ACK, 32'hF);

    // R8 start without a client (ch1 has none)
    fc = fetchCount;
    wr(1, OFF_STRM, 32'h160);
    rd(1, OFF_STAT, d); check("R8 no client keeps reset state", d, 32'h0);
    check("R7 data fetch count", fetchCount, fc + 1);
    rd(1, OFF_SBUF, d); check("R7 saved buffer from fetch", d, expSd[1] + 32'h1000);

    // R7 load only, no start
    wr(0, OFF_CFG, 32'h1);
    respEol = 1; fc = fetchCount;
    busAccess(1'b1, regAddr(0, OFF_STRM), 32'h100, 2'b10, d, e);
    check("R12 busReady low during fetch", 32'(busReady), 32'h0);
    rd(0, OFF_STAT, d); check("R8 load without start bit", d, 32'h0);
    check("R7 fetch at saved data", lastAddr, expSd[0]);
    check("R7 fetch kind data", 32'(lastKind), 32'h0);
    wr(0, OFF_STRM, 32'h120);
    rd(0, OFF_STAT, d); check("R8 started", d, statusWord(1, 0));
    check("R13 runOut while running", 32'(runOut[0]), 32'h1);
    fc = fetchCount;
    wr(0, OFF_STRM, 32'hC10);
    rd(0, OFF_STAT, d);
    check("R7 bits above 9 ignored", fetchCount, fc);

    // R13 end-of-list event
    event_pulse(0, 4'h0, 1'b1);
    rd(0, OFF_STAT, d); check("R13 eol flag in status", d, statusWord(1, 1));
    check("R13 runOut low at eol", 32'(runOut[0]), 32'h0);

    // R10 blocked continues
    fc = fetchCount;
    wr(0, OFF_CFG, 32'h0); wr(0, OFF_CMD, 32'h1); rd(0, OFF_STAT, d);
    check("R10 disabled continue ignored", fetchCount, fc);
    wr(0, OFF_CFG, 32'h3); wr(0, OFF_CMD, 32'h1); rd(0, OFF_STAT, d);
    check("R10 stopped continue ignored", fetchCount, fc);
    wr(0, OFF_CFG, 32'h1);

    // R11 accepted but descriptor still at end-of-list
    wr(0, OFF_CMD, 32'h1);
    rd(0, OFF_STAT, d); check("R11 still eol after refetch", d, statusWord(1, 1));
    check("R11 single refetch", fetchCount, fc + 1);

    // R11 resume
    respEol = 0; fc = fetchCount;
    wr(0, OFF_CMD, 32'h1);
    rd(0, OFF_STAT, d); check("R11 resumed status", d, statusWord(1, 0));
    check("R11 two fetches", fetchCount, fc + 2);
    check("R11 second fetch at next", lastAddr, expSd[0] + 32'h40);
    rd(0, OFF_SDATA, d); check("R11 saved data is next", d, expSd[0] + 32'h40);
    rd(0, OFF_SBUF, d); check("R11 saved buffer from second", d, expSd[0] + 32'h1040);
    fc = fetchCount;
    wr(0, OFF_CMD, 32'h1); rd(0, OFF_STAT, d);
    check("R10 continue ignored without descriptor eol", fetchCount, fc);

    // R9 context load
    fc = fetchCount;
    wr(2, OFF_STRM, 32'h200);
    rd(2, OFF_SDATA, d); check("R9 saved data from context", d, expGd[2] + 32'h40);
    check("R9 context fetch kind", 32'(lastKind), 32'h1);
    check("R9 context fetch address", lastAddr, expGd[2]);
    rd(2, OFF_SBUF, d); check("R9 saved buffer from context", d, expGd[2] + 32'h1000);
    wr(2, OFF_SDATA, expSd[2]);
    fc = fetchCount;
    wr(2, OFF_STRM, 32'h360);
    rd(2, OFF_STAT, d); check("R8 combined start", d, statusWord(1, 0));
    check("R9 combined fetch count", fetchCount, fc + 2);
    check("R9 data before context", 32'(kindLog[1:0]), 32'h1);
    rd(2, OFF_SDATA, d); check("R9 combined saved data", d, expGd[2] + 32'h40);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule